// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This block holds the hazard logic of a five-stage in-order integer pipeline: fetch, decode with operand read, execute, memory access and write-back. It looks at the instruction waiting in decode and at the two older instructions in execute and memory. For each of the two ALU operands it works out whether the value must come from the register file, from the result held in the memory stage, or from the result held in the write-back stage. The selects are worked out one cycle early and registered, so they are valid while the consumer sits in execute.

A loaded value is not ready in time for the instruction right behind the load. In that case the unit raises a hold for the program counter and the fetch/decode register, and at the same moment asks for a bubble in execute. This costs exactly one cycle. After it, the loaded value reaches the consumer through the write-back forwarding path. The unit assumes the pipeline advances by one stage on every clock unless it stalls the pipeline itself. It also assumes the bubble it requests enters execute with its register-write flag low.

Top module: `haz_fwd_unit`

## Requirements
- R1: With bit 0 as the most significant bit of the 32-bit word, the opcode sits in bits 0..5 (`instr[31:26]`), the first source in bits 6..10 (`instr[25:21]`) and the second source in bits 11..15 (`instr[20:16]`).
- R2: The destination of a register-register instruction (opcode 6'h00) is bits 16..20 (`instr[15:11]`). Every other writing instruction, including loads (opcode 6'h23) and immediates, writes the register in bits 11..15 (`instr[20:16]`).
- R3: If the decode instruction reads a register written by the instruction in execute, the matching select is 2'b01 (memory-stage result) in the next cycle, so back-to-back dependent ALU instructions do not stall.
- R4: If the decode instruction reads a register written by the instruction in the memory stage, the matching select is 2'b10 (write-back result) in the next cycle.
- R5: If both older instructions write the same register that is read, the nearer one (execute, giving 2'b01) wins.
- R6: A source or destination of register 0 never causes a match. Its select stays 2'b00 (register file) and it never causes a stall.
- R7: The second source is checked only for register-register instructions and stores (opcode 6'h2B). A store's data register is checked like any other operand. For all other opcodes `fwd_b_sel` is 2'b00, and bits 11..15 never cause a stall.
- R8: `pc_hold` and `ex_bubble` are both 1 in the same cycle, combinationally, exactly when the execute instruction is a writing load whose non-zero destination equals a source that the decode instruction uses.
- R9: In the cycle after a stall both selects are 2'b00. After the stall, the load has moved to the memory stage, and the held consumer then gets 2'b10 from it.
- R10: During and after synchronous active-low reset both selects are 2'b00. The code 2'b11 never appears.
- R11: An older instruction whose register-write flag is low never causes a forward or a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_instr | input | 32 | Instruction word in decode |
| ex_instr | input | 32 | Instruction word in execute |
| ex_reg_wr | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_instr | input | 32 | Instruction word in the memory stage |
| mem_reg_wr | input | 1 | Memory-stage instruction writes a register |
| fwd_a_sel | output | 2 | First ALU operand source: 00 register file, 01 memory stage, 10 write-back stage |
| fwd_b_sel | output | 2 | Second ALU operand source, same encoding |
| pc_hold | output | 1 | Hold the program counter and the fetch/decode register |
| ex_bubble | output | 1 | Insert a bubble into execute |

## Verification
The checker watches several properties on every cycle. It checks that no select ever carries the unused code. It checks that a stall is raised only by a writing load in execute, and never when that stage's write flag is low. It checks that the cycle after a stall has both selects at the register file, and that no forward is ever taken for a zero first source. The destination decode per opcode class is shown only by the bench's scenarios, along with the near-over-far priority, the rule that the second source counts only for register-register and store instructions, and the exact one-cycle recovery from a load-use case. The bench compares these against its own model over directed cases and random instruction mixes.

// File: rtl/hfu_pkg.sv
// Shared widths, field positions, select encoding and field helpers for the
// hazard unit. Field positions assume a 32-bit word with the opcode on top.
package hfu_pkg;
    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int REG_W   = 5;
    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int RS1_LSB = OPC_LSB - REG_W;
    localparam int RS2_LSB = RS1_LSB - REG_W;
    localparam int RD_LSB  = RS2_LSB - REG_W;

    typedef logic [REG_W-1:0] reg_idx_t;
    typedef logic [OPC_W-1:0] opc_t;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_MEM = 2'b01,
        SEL_WB  = 2'b10
    } opnd_sel_e;

    typedef struct packed {
        reg_idx_t rs1;
        reg_idx_t rs2;
        logic     rs2_used;
    } src_fields_t;

    // Destination register: the third field for register-register ops, else the second.
    function automatic reg_idx_t dest_of(input logic [INSTR_W-1:0] instr, input opc_t rr_opc);
        if (instr[OPC_LSB +: OPC_W] == rr_opc)
            return instr[RD_LSB +: REG_W];
        return instr[RS2_LSB +: REG_W];
    endfunction
endpackage

// File: rtl/hfu_src_decode.sv
// Extracts the source register fields of the decode-stage instruction and
// marks whether the second field is a real source operand (register-register
// ops and stores). Assumes loads and immediates use that field as destination.
module hfu_src_decode
    import hfu_pkg::*;
#(
    parameter opc_t RR_OPC = 6'h00,
    parameter opc_t ST_OPC = 6'h2B
) (
    input  logic [INSTR_W-1:0] instr,
    output src_fields_t        fields
);
    opc_t opc;

    // Slice the fields and classify the second field by opcode.
    always_comb begin
        opc             = instr[OPC_LSB +: OPC_W];
        fields.rs1      = instr[RS1_LSB +: REG_W];
        fields.rs2      = instr[RS2_LSB +: REG_W];
        fields.rs2_used = (opc == RR_OPC) || (opc == ST_OPC);
    end
endmodule

// File: rtl/hfu_fwd_pick.sv
// Chooses the source of one ALU operand from a near (execute, becomes memory
// stage) and a far (memory, becomes write-back) producer. Register 0 and
// unused operands always read the register file; the near producer wins.
module hfu_fwd_pick
    import hfu_pkg::*;
(
    input  reg_idx_t  src,
    input  logic      src_used,
    input  reg_idx_t  near_dst,
    input  logic      near_wr,
    input  reg_idx_t  far_dst,
    input  logic      far_wr,
    output opnd_sel_e sel
);
    logic live;

    // Priority compare: nearer producer first, then the older one.
    always_comb begin
        live = src_used && (src != '0);
        if (live && near_wr && (near_dst == src))
            sel = SEL_MEM;
        else if (live && far_wr && (far_dst == src))
            sel = SEL_WB;
        else
            sel = SEL_RF;
    end
endmodule

// File: rtl/hfu_load_use.sv
// Flags a load in execute whose destination is read by the decode-stage
// instruction; such a value cannot be forwarded in time, so one stall is due.
module hfu_load_use
    import hfu_pkg::*;
(
    input  src_fields_t id_src,
    input  reg_idx_t    ex_dst,
    input  logic        ex_wr,
    input  logic        ex_load,
    output logic        stall
);
    logic hit_a, hit_b;

    // Compare the load destination with each source actually used.
    always_comb begin
        hit_a = (id_src.rs1 == ex_dst);
        hit_b = id_src.rs2_used && (id_src.rs2 == ex_dst);
        stall = ex_load && ex_wr && (ex_dst != '0) && (hit_a || hit_b);
    end
endmodule

// File: rtl/haz_fwd_unit.sv
// Hazard unit top: works out both operand selects for the decode instruction
// one cycle ahead and registers them for use in execute; raises hold and
// bubble for a load-use case. Assumes the pipeline advances every cycle it
// is not stalled and that the inserted bubble has its write flag low.
module haz_fwd_unit
    import hfu_pkg::*;
#(
    parameter opc_t RR_OPC = 6'h00,
    parameter opc_t ST_OPC = 6'h2B
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] id_instr,
    input  logic [INSTR_W-1:0] ex_instr,
    input  logic               ex_reg_wr,
    input  logic               ex_is_load,
    input  logic [INSTR_W-1:0] mem_instr,
    input  logic               mem_reg_wr,
    output logic [1:0]         fwd_a_sel,
    output logic [1:0]         fwd_b_sel,
    output logic               pc_hold,
    output logic               ex_bubble
);
    localparam int N_OPND = 2;

    src_fields_t id_src;
    reg_idx_t    ex_dst, mem_dst;
    logic        stall;
    opnd_sel_e   sel_d [N_OPND];
    opnd_sel_e   sel_q [N_OPND];

    // Destination fields of the two older instructions, by opcode class.
    always_comb begin
        ex_dst  = dest_of(ex_instr, RR_OPC);
        mem_dst = dest_of(mem_instr, RR_OPC);
    end

    hfu_src_decode #(.RR_OPC(RR_OPC), .ST_OPC(ST_OPC)) u_src (
        .instr  (id_instr),
        .fields (id_src)
    );

    hfu_load_use u_lu (
        .id_src  (id_src),
        .ex_dst  (ex_dst),
        .ex_wr   (ex_reg_wr),
        .ex_load (ex_is_load),
        .stall   (stall)
    );

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        hfu_fwd_pick u_pick (
            .src      ((g == 0) ? id_src.rs1 : id_src.rs2),
            .src_used ((g == 0) ? 1'b1 : id_src.rs2_used),
            .near_dst (ex_dst),
            .near_wr  (ex_reg_wr),
            .far_dst  (mem_dst),
            .far_wr   (mem_reg_wr),
            .sel      (sel_d[g])
        );

        // Carry the select into execute; a bubble reads the register file.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_q[g] <= SEL_RF;
            else if (stall)
                sel_q[g] <= SEL_RF;
            else
                sel_q[g] <= sel_d[g];
        end
    end

    assign fwd_a_sel = sel_q[0];
    assign fwd_b_sel = sel_q[1];
    assign pc_hold   = stall;
    assign ex_bubble = stall;
endmodule

// File: rtl/hfu_checker.sv
// Cycle-by-cycle properties of the hazard unit, bound to the top module.
module hfu_checker
    import hfu_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] id_instr,
    input logic               ex_reg_wr,
    input logic               ex_is_load,
    input logic [1:0]         fwd_a_sel,
    input logic [1:0]         fwd_b_sel,
    input logic               pc_hold,
    input logic               ex_bubble
);
    assert_sel_a_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_a_sel != 2'b11);
    assert_sel_b_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_b_sel != 2'b11);
    assert_stall_from_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_hold || ex_bubble) |-> (ex_is_load && ex_reg_wr));
    assert_no_stall_without_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_reg_wr |-> !pc_hold);
    assert_bubble_reads_rf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ex_bubble |=> (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00));
    assert_r0_not_forwarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a_sel != 2'b00) |-> ($past(id_instr[RS1_LSB +: REG_W]) != '0));
endmodule

bind haz_fwd_unit hfu_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .id_instr   (id_instr),
    .ex_reg_wr  (ex_reg_wr),
    .ex_is_load (ex_is_load),
    .fwd_a_sel  (fwd_a_sel),
    .fwd_b_sel  (fwd_b_sel),
    .pc_hold    (pc_hold),
    .ex_bubble  (ex_bubble)
);

// File: tb/haz_fwd_unit_tb.sv
`timescale 1ns/1ps
module haz_fwd_unit_tb;
    localparam logic [5:0] OP_RR  = 6'h00;
    localparam logic [5:0] OP_LD  = 6'h23;
    localparam logic [5:0] OP_ST  = 6'h2B;
    localparam logic [5:0] OP_IMM = 6'h08;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] id_instr = '0, ex_instr = '0, mem_instr = '0;
    logic        ex_reg_wr = 1'b0, ex_is_load = 1'b0, mem_reg_wr = 1'b0;
    logic [1:0]  fwd_a_sel, fwd_b_sel;
    logic        pc_hold, ex_bubble;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    haz_fwd_unit u_dut (
        .clk(clk), .rst_n(rst_n), .id_instr(id_instr), .ex_instr(ex_instr),
        .ex_reg_wr(ex_reg_wr), .ex_is_load(ex_is_load), .mem_instr(mem_instr),
        .mem_reg_wr(mem_reg_wr), .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .pc_hold(pc_hold), .ex_bubble(ex_bubble)
    );

    function automatic logic [31:0] mk(input logic [5:0] op, input int a, input int b, input int c);
        return {op, 5'(a), 5'(b), 5'(c), 11'b0};
    endfunction

    function automatic logic [4:0] f_rs1(input logic [31:0] i); return i[25:21]; endfunction
    function automatic logic [4:0] f_rs2(input logic [31:0] i); return i[20:16]; endfunction
    function automatic logic [4:0] f_dst(input logic [31:0] i);
        return (i[31:26] == OP_RR) ? i[15:11] : i[20:16];
    endfunction
    function automatic bit f_b_used(input logic [31:0] i);
        return (i[31:26] == OP_RR) || (i[31:26] == OP_ST);
    endfunction

    function automatic logic [1:0] m_sel(input logic [4:0] s, input bit used,
                                         input logic [31:0] exi, input bit exw,
                                         input logic [31:0] memi, input bit memw);
        if (!used || s == 0) return 2'b00;
        if (exw && f_dst(exi) == s) return 2'b01;
        if (memw && f_dst(memi) == s) return 2'b10;
        return 2'b00;
    endfunction

    function automatic bit m_stall(input logic [31:0] idi, input logic [31:0] exi,
                                   input bit exw, input bit exl);
        logic [4:0] d;
        d = f_dst(exi);
        if (!(exl && exw) || d == 0) return 1'b0;
        return (f_rs1(idi) == d) || (f_b_used(idi) && f_rs2(idi) == d);
    endfunction

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Apply one cycle of inputs (called at a falling edge), check the stall
    // outputs combinationally, then check the registered selects one edge on.
    task automatic step(input logic [31:0] idi, input logic [31:0] exi, input bit exw,
                        input bit exl, input logic [31:0] memi, input bit memw,
                        input string tag);
        bit         st;
        logic [1:0] ea, eb;
        id_instr = idi; ex_instr = exi; ex_reg_wr = exw; ex_is_load = exl;
        mem_instr = memi; mem_reg_wr = memw;
        #1;
        st = m_stall(idi, exi, exw, exl);
        ea = st ? 2'b00 : m_sel(f_rs1(idi), 1'b1, exi, exw, memi, memw);
        eb = st ? 2'b00 : m_sel(f_rs2(idi), f_b_used(idi), exi, exw, memi, memw);
        check({tag, " pc_hold"}, {1'b0, pc_hold}, {1'b0, st});
        check({tag, " ex_bubble"}, {1'b0, ex_bubble}, {1'b0, st});
        @(negedge clk);
        check({tag, " fwd_a_sel"}, fwd_a_sel, ea);
        check({tag, " fwd_b_sel"}, fwd_b_sel, eb);
    endtask

    function automatic logic [5:0] rnd_op();
        case ($urandom % 4)
            0: return OP_RR;
            1: return OP_LD;
            2: return OP_ST;
            default: return OP_IMM;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R10 reset fwd_a_sel", fwd_a_sel, 2'b00);
        check("R10 reset fwd_b_sel", fwd_b_sel, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R3: back-to-back dependent ALU op, near forward on operand a
        step(mk(OP_RR,1,4,5), mk(OP_RR,2,3,1), 1, 0, mk(OP_RR,0,0,0), 0, "R3 near fwd");
        // R4: producer two ahead feeds operand b
        step(mk(OP_RR,4,1,5), mk(OP_RR,2,3,6), 1, 0, mk(OP_RR,2,3,1), 1, "R4 far fwd");
        // R5: both older instructions write r1, near wins
        step(mk(OP_RR,1,1,5), mk(OP_RR,2,3,1), 1, 0, mk(OP_RR,2,3,1), 1, "R5 priority");
        // R2: load destination in the second field, forwarded from memory stage
        step(mk(OP_RR,1,0,5), mk(OP_IMM,0,0,0), 0, 0, mk(OP_LD,7,1,0), 1, "R2 load dst");
        // R6: register 0 never forwarded
        step(mk(OP_RR,0,0,5), mk(OP_RR,2,3,0), 1, 0, mk(OP_IMM,2,0,0), 1, "R6 r0");
        // R7: immediate's second field is not a source, even against a load
        step(mk(OP_IMM,2,1,0), mk(OP_LD,3,1,0), 1, 1, mk(OP_RR,0,0,0), 0, "R7 imm no stall");
        // R7: store data register is checked
        step(mk(OP_ST,2,1,0), mk(OP_RR,2,3,1), 1, 0, mk(OP_RR,0,0,0), 0, "R7 store data");
        // R8 then R9: load-use stall, bubble, then write-back forward
        step(mk(OP_RR,1,4,5), mk(OP_LD,3,1,0), 1, 1, mk(OP_RR,0,0,0), 0, "R8 load use");
        step(mk(OP_RR,1,4,5), mk(OP_RR,0,0,0), 0, 0, mk(OP_LD,3,1,0), 1, "R9 after stall");
        // R8: store data depending on a load also stalls
        step(mk(OP_ST,2,1,0), mk(OP_LD,3,1,0), 1, 1, mk(OP_RR,0,0,0), 0, "R8 store load use");
        // R11: write flags low, no forward and no stall
        step(mk(OP_RR,1,1,5), mk(OP_LD,2,1,0), 0, 1, mk(OP_RR,2,3,1), 0, "R11 no wr");
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a, b, c;
            logic [5:0]  eo;
            eo = rnd_op();
            a = mk(rnd_op(), $urandom % 4, $urandom % 4, $urandom % 4);
            b = mk(eo, $urandom % 4, $urandom % 4, $urandom % 4);
            c = mk(rnd_op(), $urandom % 4, $urandom % 4, $urandom % 4);
            step(a, b, 1'($urandom % 2), (eo == OP_LD) ? 1'($urandom % 2) : 1'b0,
                 c, 1'($urandom % 2), "R3 R4 R5 R8 random");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule